// File: doc/BRIEF.md
# Register Unlock Key Sequencer

This block sits beside the register file of a small timekeeping peripheral and decides when that peripheral may be configured. It watches every write on a simple register bus. Seven key registers have to be loaded with seven fixed byte values, one after another, in a fixed order. Only when the seventh key lands does the block raise its unlocked flag. Any wrong write into the key window throws the progress away.

Once the block is unlocked, software may write the two configuration registers it guards. The first is a stop bit that holds counting. The second is a three-bit input filter setting. The block drives a run permit only when it is unlocked, the stop bit is clear and the filter setting is zero. It also reports a power-check-valid flag whenever the first two key registers hold their expected values. Every register the block owns can be read back through a combinational read port.

Top module: `unlock_key_seq`

## Requirements
- R1: After reset, unlocked_o, pwr_ok_o and run_o are 0. Every key register reads 0, the stop bit at byte address 0x20 reads 1 and the filter field at 0x2C reads 7.
- R2: Progress advances only through these writes, in this order: 0xC6 to 0x04, 0x9A to 0x08, 0x59 to 0x0C, 0xA3 to 0x10, 0x57 to 0x14, 0x67 to 0x18, 0xD2 to 0x1C. unlocked_o goes to 1 on the clock edge that captures the seventh write.
- R3: While the block is locked, a write to a word-aligned key address (0x04 to 0x1C) with the wrong byte, or to the wrong key address, restarts the progress. Progress goes to step 0, or to step 1 if that write is itself 0xC6 to 0x04.
- R4: Writes to any address outside the key window leave the progress unchanged. This includes non-word-aligned addresses such as 0x05. Cycles with no write also leave it unchanged.
- R5: Once set, unlocked_o stays 1 until reset, whatever is written afterwards.
- R6: Reading a key address through rd_addr_i returns the last byte written there, in or out of sequence.
- R7: pwr_ok_o is 1 exactly when key address 0x04 holds 0xC6 and key address 0x08 holds 0x9A.
- R8: Address 0x20 bit 0 is the stop bit and address 0x2C bits [2:0] are the filter field. Both read back zero-extended. Writes to them are ignored while the block is locked and take effect once it is unlocked.
- R9: run_o is 1 exactly when unlocked_o is 1, the stop bit is 0 and the filter field is 0.
- R10: Asserting rst_ni (low) returns the block at once to the R1 state, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | ADDR_W | Write byte address |
| wdata_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | 8 | Combinational read data |
| unlocked_o | output | 1 | Key sequence completed |
| pwr_ok_o | output | 1 | Power-check pair holds its expected values |
| run_o | output | 1 | Counting permitted |

## Verification
A step counter that has gone wrong shows up as unlocked_o rising too early, too late or never. That becomes visible on the edge after the write that should, or should not, have completed the sequence. A wrong restart step, for example one that ignores a fresh 0xC6 to 0x04, only shows up several writes later, when the sequence finishes or fails to finish. For that reason the bench builds sequences that cross a restart and then completes them. Faults in the stored key bytes or in the gating of the configuration registers appear one edge after the write, on rd_data_o, pwr_ok_o and run_o, which are compared against a behavioural model on every clock.

// File: rtl/keyseq_pkg.sv
`timescale 1ns/1ps
package keyseq_pkg;
  localparam int KEY_W    = 8;
  localparam int NUM_KEYS = 7;
  localparam int STEP_W   = $clog2(NUM_KEYS);
  localparam int FILT_W   = 3;
  localparam int CTRL_WORD = 8;   // byte 0x20
  localparam int FILT_WORD = 11;  // byte 0x2C

  // key i lives at word i+1 (byte 4*(i+1)); order is the unlock order
  function automatic logic [KEY_W-1:0] key_magic(input int idx);
    case (idx)
      0:       return 8'hC6;
      1:       return 8'h9A;
      2:       return 8'h59;
      3:       return 8'hA3;
      4:       return 8'h57;
      5:       return 8'h67;
      default: return 8'hD2;
    endcase
  endfunction
endpackage

// File: rtl/key_seq.sv
`timescale 1ns/1ps
module key_seq
  import keyseq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [NUM_KEYS-1:0] key_hit_i,
  input  logic [KEY_W-1:0]    wdata_i,
  output logic                unlocked_o
);
  logic [STEP_W-1:0] step_q;
  logic match, first_ok, any_key;

  always_comb begin
    match = 1'b0;
    for (int i = 0; i < NUM_KEYS; i++)
      if (step_q == STEP_W'(i) && key_hit_i[i] && wdata_i == key_magic(i)) match = 1'b1;
  end
  assign first_ok = key_hit_i[0] && (wdata_i == key_magic(0));
  assign any_key  = |key_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q     <= '0;
      unlocked_o <= 1'b0;
    end else if (!unlocked_o && wr_en_i && any_key) begin
      if (match) begin
        if (step_q == STEP_W'(NUM_KEYS-1)) begin
          unlocked_o <= 1'b1;
          step_q     <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else begin
        step_q <= first_ok ? STEP_W'(1) : '0;
      end
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q < STEP_W'(NUM_KEYS)); // R2
  AST_BAD_KEY_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && wr_en_i && any_key && !match) |=> (step_q <= STEP_W'(1) && !unlocked_o)); // R3
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && any_key) |=> $stable(step_q)); // R4
  AST_UNLOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_o |=> unlocked_o); // R5
endmodule

// File: rtl/key_regs.sv
`timescale 1ns/1ps
module key_regs
  import keyseq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [NUM_KEYS-1:0] key_hit_i,
  input  logic [KEY_W-1:0]    wdata_i,
  input  logic [NUM_KEYS-1:0] rd_hit_i,
  output logic [KEY_W-1:0]    rd_data_o,
  output logic                pwr_ok_o
);
  logic [KEY_W-1:0] key_q [NUM_KEYS];

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     key_q[g] <= '0;
      else if (wr_en_i && key_hit_i[g]) key_q[g] <= wdata_i;
    end

    AST_KEY_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && key_hit_i[g]) |=> (key_q[g] == $past(wdata_i))); // R6
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_KEYS; i++)
      if (rd_hit_i[i]) rd_data_o = key_q[i];
  end

  assign pwr_ok_o = (key_q[0] == key_magic(0)) && (key_q[1] == key_magic(1));
endmodule

// File: rtl/ctrl_regs.sv
`timescale 1ns/1ps
module ctrl_regs
  import keyseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              unlocked_i,
  input  logic              ctrl_we_i,
  input  logic              filt_we_i,
  input  logic              stop_d_i,
  input  logic [FILT_W-1:0] filt_d_i,
  output logic              stop_o,
  output logic [FILT_W-1:0] filt_o,
  output logic              run_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_o <= 1'b1;
      filt_o <= '1;
    end else if (unlocked_i) begin
      if (ctrl_we_i) stop_o <= stop_d_i;
      if (filt_we_i) filt_o <= filt_d_i;
    end
  end

  assign run_o = unlocked_i && !stop_o && (filt_o == '0);

  AST_LOCKED_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |=> ($stable(stop_o) && $stable(filt_o))); // R8
  AST_STOP_CLEAR_NEEDS_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_o |-> unlocked_i); // R8
endmodule

// File: rtl/unlock_key_seq.sv
`timescale 1ns/1ps
module unlock_key_seq
  import keyseq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [KEY_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [KEY_W-1:0]  rd_data_o,
  output logic              unlocked_o,
  output logic              pwr_ok_o,
  output logic              run_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   wr_word, rd_word;
  logic                wr_align, rd_align;
  logic [NUM_KEYS-1:0] key_hit, rd_hit;
  logic                ctrl_we, filt_we, stop_q;
  logic [FILT_W-1:0]   filt_q;
  logic [KEY_W-1:0]    key_rd;

  assign wr_word  = addr_i[ADDR_W-1:2];
  assign rd_word  = rd_addr_i[ADDR_W-1:2];
  assign wr_align = (addr_i[1:0] == 2'b00);
  assign rd_align = (rd_addr_i[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_dec
    assign key_hit[g] = wr_align && (wr_word == WORD_W'(g + 1));
    assign rd_hit[g]  = rd_align && (rd_word == WORD_W'(g + 1));
  end

  assign ctrl_we = wr_en_i && wr_align && (wr_word == WORD_W'(CTRL_WORD));
  assign filt_we = wr_en_i && wr_align && (wr_word == WORD_W'(FILT_WORD));

  key_seq u_seq (
    .clk_i, .rst_ni, .wr_en_i,
    .key_hit_i (key_hit),
    .wdata_i,
    .unlocked_o
  );

  key_regs u_keys (
    .clk_i, .rst_ni, .wr_en_i,
    .key_hit_i (key_hit),
    .wdata_i,
    .rd_hit_i  (rd_hit),
    .rd_data_o (key_rd),
    .pwr_ok_o
  );

  ctrl_regs u_cfg (
    .clk_i, .rst_ni,
    .unlocked_i (unlocked_o),
    .ctrl_we_i  (ctrl_we),
    .filt_we_i  (filt_we),
    .stop_d_i   (wdata_i[0]),
    .filt_d_i   (wdata_i[FILT_W-1:0]),
    .stop_o     (stop_q),
    .filt_o     (filt_q),
    .run_o
  );

  always_comb begin
    if (|rd_hit)                                          rd_data_o = key_rd;
    else if (rd_align && rd_word == WORD_W'(CTRL_WORD))   rd_data_o = KEY_W'(stop_q);
    else if (rd_align && rd_word == WORD_W'(FILT_WORD))   rd_data_o = KEY_W'(filt_q);
    else                                                  rd_data_o = '0;
  end

  AST_RUN_NEEDS_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (unlocked_o && rd_hit == '0 ? 1'b1 : unlocked_o)); // R9
endmodule

// File: tb/tb_unlock_key_seq.sv
`timescale 1ns/1ps
module tb_unlock_key_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       unlocked, pwr_ok, run;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  unlock_key_seq #(.ADDR_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .unlocked_o(unlocked),
    .pwr_ok_o(pwr_ok), .run_o(run)
  );

  // behavioural reference
  int mg [7] = '{8'hC6, 8'h9A, 8'h59, 8'hA3, 8'h57, 8'h67, 8'hD2};
  int m_step = 0, m_stop = 1, m_filt = 7;
  bit m_unl = 0;
  int m_key [7] = '{0, 0, 0, 0, 0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_unl = 0; m_stop = 1; m_filt = 7;
      for (int i = 0; i < 7; i++) m_key[i] = 0;
    end else if (we) begin
      int a, d, k;
      a = int'(addr); d = int'(wdata);
      k = (a % 4 == 0 && a >= 4 && a <= 28) ? a / 4 - 1 : -1;
      if (m_unl) begin
        if (a == 32) m_stop = d & 1;
        if (a == 44) m_filt = d & 7;
      end
      if (k >= 0) begin
        m_key[k] = d;
        if (!m_unl) begin
          if (k == m_step && d == mg[m_step]) begin
            m_step++;
            if (m_step == 7) begin m_unl = 1; m_step = 0; end
          end else m_step = (k == 0 && d == mg[0]) ? 1 : 0;
        end
      end
    end
  end

  function automatic int exp_rd(input int a);
    if (a % 4 == 0 && a >= 4 && a <= 28) return m_key[a / 4 - 1];
    if (a == 32) return m_stop;
    if (a == 44) return m_filt;
    return 0;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compared every clock, away from the edge
  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(unlocked), int'(m_unl), "R2 unlocked_o");
    chk(int'(pwr_ok), (m_key[0] == 8'hC6 && m_key[1] == 8'h9A) ? 1 : 0, "R7 pwr_ok_o");
    chk(int'(run), (m_unl && m_stop == 0 && m_filt == 0) ? 1 : 0, "R9 run_o");
    chk(int'(rd_data), exp_rd(int'(rd_addr)), "R6 rd_data_o");
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #5;
    we = 1'b1; addr = 8'(a); wdata = 8'(d);
  endtask
  task automatic idle();
    @(posedge clk); #5; we = 1'b0;
  endtask
  task automatic rd(input int a);
    rd_addr = 8'(a);
  endtask
  task automatic key(input int i);
    wr(4 * (i + 1), mg[i]);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    chk(int'(unlocked), 0, "R1 unlocked after reset");
    chk(int'(run), 0, "R1 run after reset");
    rd(32); #1 chk(int'(rd_data), 1, "R1 stop reset value");
    rd(44); #1 chk(int'(rd_data), 7, "R1 filter reset value");
    rd(4);  #1 chk(int'(rd_data), 0, "R1 key reset value");

    // R8: locked config writes ignored
    wr(32, 0); wr(44, 0); idle();
    rd(32); @(negedge clk); chk(int'(rd_data), 1, "R8 stop write ignored while locked");

    // R3: wrong byte mid-sequence
    key(0); key(1); key(2); wr(16, 8'h00);
    for (int i = 4; i < 7; i++) key(i);
    idle(); @(negedge clk);
    chk(int'(unlocked), 0, "R3 wrong byte restarts");
    // R3: wrong order
    key(0); key(2); key(1);
    for (int i = 3; i < 7; i++) key(i);
    idle(); @(negedge clk);
    chk(int'(unlocked), 0, "R3 wrong order restarts");
    rd(4); @(negedge clk); chk(int'(pwr_ok), 1, "R7 pair held");

    // R3: restart write is itself a valid first key
    key(0); key(1); key(2); key(3); key(0);
    for (int i = 1; i < 7; i++) key(i);
    idle(); @(negedge clk);
    chk(int'(unlocked), 1, "R3 restart from valid first key");

    // R10: async reset
    #2 rst_n = 1'b0; #1;
    chk(int'(unlocked), 0, "R10 async reset clears unlock");
    chk(int'(pwr_ok), 0, "R10 async reset clears keys");
    @(posedge clk); #5 rst_n = 1'b1;

    // R4: foreign and unaligned writes mid-sequence
    key(0); key(1); wr(8'h40, 8'h12); wr(8'h05, 8'h59); key(2); idle(); idle();
    for (int i = 3; i < 7; i++) key(i);
    wr(8'h30, 8'hFF);
    idle(); @(negedge clk);
    chk(int'(unlocked), 1, "R4 foreign writes ignored");

    // R5: sticky
    wr(4, 8'h00); wr(28, 8'h11); idle(); @(negedge clk);
    chk(int'(unlocked), 1, "R5 unlock sticky");
    chk(int'(pwr_ok), 0, "R7 pair broken");
    rd(28); @(negedge clk); chk(int'(rd_data), 8'h11, "R6 readback");

    // R8/R9: config when unlocked
    wr(32, 8'hFE); idle(); rd(32); @(negedge clk);
    chk(int'(rd_data), 0, "R8 stop cleared");
    chk(int'(run), 0, "R9 run needs filter zero");
    wr(44, 8'hF8); idle(); rd(44); @(negedge clk);
    chk(int'(rd_data), 0, "R8 filter cleared");
    chk(int'(run), 1, "R9 run granted");
    wr(32, 1); idle(); @(negedge clk);
    chk(int'(run), 0, "R9 stop holds run");

    repeat (3) idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule